// File: doc/BRIEF.md
# Many-time-programmable byte flash control model

This block is a synthesizable behavioural model of a byte-wide flash memory that is erased and reprogrammed by an external programmer. The operating mode depends only on pin levels. Chip enable, output enable and write enable are active low. Two extra flags mark when a high-voltage level is present on the output-enable pin and on address bit 9. There are no command sequences. In normal use the block acts as a read-only memory: the addressed byte appears on the data output while chip enable and output enable are low.

Programming and erasing need the high-voltage flag on output enable and a falling edge of write enable. A program can only clear bits, so the new byte is the old byte ANDed with the supplied data. Only a whole-array erase returns bits to one. Each operation runs for a parameterised number of clock cycles, and the array changes when that count ends. An identification mode returns a maker code and a size-dependent device code. The block runs on one clock. Pin levels are sampled on its rising edge, and the read path from pins to data output is combinational.

Top module: `mtp_flash`

## Requirements
- R1: After reset every byte of the array reads FFh.
- R2: With chip enable low, output enable low, its high-voltage flag clear and write enable high, `dout_en` is 1 and `dout` shows the byte at `addr` (address-bit-9 flag clear).
- R3: `dout_en` is 0 whenever chip enable is high, output enable is high, the output-enable high-voltage flag is set, or write enable is low.
- R4: A falling edge of write enable, seen on a clock edge while chip enable is low, the output-enable high-voltage flag is set and the address-bit-9 flag is clear, starts a program of the byte at `addr` with `din`. The array holds the new value PROG_CYC clock edges after the starting edge.
- R5: A program stores the old byte ANDed with `din`, so a bit already at 0 stays 0 even when `din` holds 1 there.
- R6: A falling edge of write enable with chip enable low and both high-voltage flags set starts an erase, whatever `addr` and `din` hold. After ERASE_CYC cycles every byte reads FFh.
- R7: With chip enable low, output enable low (flag clear), write enable high and the address-bit-9 flag set, `dout` is BFh when `addr[0]` is 0. When `addr[0]` is 1 it is the device code selected by VARIANT: 0 gives C4h, 1 gives C5h, 2 gives C6h, 3 gives C2h.
- R8: While write enable stays high, and while chip enable is high, no program or erase starts and the array is unchanged, whatever the other pins do.
- R9: Write-enable falling edges that arrive while an operation is still counting are ignored.
- R10: While an operation is counting, a read returns FFh when BUSY_ONES is 1, and the array contents from before the operation when it is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Model clock; pin levels are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; sets the array to the erased state |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low (normal logic level) |
| we_n | input | 1 | Write enable, active low; its falling edge starts a program or an erase |
| oe_hv | input | 1 | Flag: high-voltage level present on the output-enable pin |
| a9_hv | input | 1 | Flag: high-voltage level present on address bit 9 |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Data to program |
| dout | output | 8 | Read or identification data; 00h while not driving |
| dout_en | output | 1 | Output drive enable for the data bus |

## Verification
The bench counts the exact busy window of a program. It reads the target byte on every cycle and expects FFh while the count runs, then the new value on the first cycle after it ends. A design that commits early, or that is off by one in its counter, shows the new value a cycle too soon or too late. The bench programs a byte that already has cleared bits with data that holds ones in those bits. A design that overwrites instead of ANDing then reads back the wrong value. It also sends a second write-enable pulse to another address while a program is running; a design that restarts or retargets on it changes that second byte. The inhibit cases hold the program levels with write enable high, and pulse write enable with chip enable high. An erase with arbitrary address and data must clear the whole array. This catches decoders that let a level rather than an edge start an operation, or that look at the wrong pins.

// File: rtl/mtp_pkg.sv
package mtp_pkg;

  typedef enum logic [2:0] {
    M_STANDBY,
    M_OUTOFF,
    M_READ,
    M_IDENT,
    M_PROG,
    M_ERASE,
    M_LOCKED
  } mtp_mode_e;

  localparam logic [7:0] MAKER_CODE = 8'hBF;
  localparam logic [7:0] BLANK_BYTE = 8'hFF;

  // Device code per size variant (0: 64K, 1: 128K, 2: 256K, 3: 512K bytes)
  function automatic logic [7:0] dev_code(input int unsigned variant);
    case (variant)
      0:       dev_code = 8'hC4;
      1:       dev_code = 8'hC5;
      2:       dev_code = 8'hC6;
      default: dev_code = 8'hC2;
    endcase
  endfunction

endpackage

// File: rtl/mtp_mode_dec.sv
module mtp_mode_dec
  import mtp_pkg::*;
(
  input  logic      ce_n,
  input  logic      oe_n,
  input  logic      we_n,
  input  logic      oe_hv,
  input  logic      a9_hv,
  output mtp_mode_e mode
);

  always_comb begin
    if (ce_n) begin
      mode = M_STANDBY;
    end else if (oe_hv) begin
      if (we_n)       mode = M_LOCKED;
      else if (a9_hv) mode = M_ERASE;
      else            mode = M_PROG;
    end else if (oe_n) begin
      mode = M_OUTOFF;
    end else if (!we_n) begin
      mode = M_LOCKED;
    end else if (a9_hv) begin
      mode = M_IDENT;
    end else begin
      mode = M_READ;
    end
  end

endmodule

// File: rtl/mtp_busy_timer.sv
module mtp_busy_timer #(
  parameter int unsigned PROG_CYC  = 16,
  parameter int unsigned ERASE_CYC = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_prog,
  input  logic start_erase,
  output logic busy,
  output logic done
);

  localparam int unsigned MAX_CYC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign busy = |cnt_q;
  assign done = (cnt_q == CNT_W'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (start_erase)      cnt_d = CNT_W'(ERASE_CYC);
    else if (start_prog)  cnt_d = CNT_W'(PROG_CYC);
    else if (busy)        cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/mtp_array.sv
module mtp_array #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              clr_all,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    logic hit;
    assign hit = wr_en && (wr_addr == ADDR_W'(g));

    // Erase wins over program; a program can only clear bits.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mem[g] <= mtp_pkg::BLANK_BYTE;
      else if (clr_all) mem[g] <= mtp_pkg::BLANK_BYTE;
      else if (hit)     mem[g] <= mem[g] & wr_data;
    end
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/mtp_flash.sv
module mtp_flash
  import mtp_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned VARIANT   = 0,
  parameter int unsigned PROG_CYC  = 16,
  parameter int unsigned ERASE_CYC = 128,
  parameter bit          BUSY_ONES = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              oe_hv,
  input  logic              a9_hv,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              dout_en
);

  localparam logic [7:0] DEV_CODE = dev_code(VARIANT);

  mtp_mode_e mode;
  logic      we_q;
  logic      we_fall;
  logic      busy, done;
  logic      start_prog, start_erase;
  logic      op_erase_q, op_erase_d;
  logic [ADDR_W-1:0] op_addr_q, op_addr_d;
  logic [7:0] op_data_q, op_data_d;
  logic [7:0] rd_data;

  mtp_mode_dec u_dec (
    .ce_n  (ce_n),
    .oe_n  (oe_n),
    .we_n  (we_n),
    .oe_hv (oe_hv),
    .a9_hv (a9_hv),
    .mode  (mode)
  );

  assign we_fall     = we_q & ~we_n;
  assign start_prog  = we_fall & ~busy & (mode == M_PROG);
  assign start_erase = we_fall & ~busy & (mode == M_ERASE);

  always_comb begin
    op_erase_d = op_erase_q;
    op_addr_d  = op_addr_q;
    op_data_d  = op_data_q;
    if (start_erase) begin
      op_erase_d = 1'b1;
    end else if (start_prog) begin
      op_erase_d = 1'b0;
      op_addr_d  = addr;
      op_data_d  = din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q       <= 1'b1;
      op_erase_q <= 1'b0;
      op_addr_q  <= '0;
      op_data_q  <= '1;
    end else begin
      we_q       <= we_n;
      op_erase_q <= op_erase_d;
      op_addr_q  <= op_addr_d;
      op_data_q  <= op_data_d;
    end
  end

  mtp_busy_timer #(
    .PROG_CYC  (PROG_CYC),
    .ERASE_CYC (ERASE_CYC)
  ) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_prog  (start_prog),
    .start_erase (start_erase),
    .busy        (busy),
    .done        (done)
  );

  mtp_array #(
    .ADDR_W (ADDR_W)
  ) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (done & ~op_erase_q),
    .wr_addr (op_addr_q),
    .wr_data (op_data_q),
    .clr_all (done & op_erase_q),
    .rd_addr (addr),
    .rd_data (rd_data)
  );

  always_comb begin
    dout_en = (mode == M_READ) || (mode == M_IDENT);
    dout    = 8'h00;
    if (mode == M_IDENT)           dout = addr[0] ? DEV_CODE : MAKER_CODE;
    else if (mode == M_READ) begin
      if (busy && BUSY_ONES)       dout = BLANK_BYTE;
      else                         dout = rd_data;
    end
  end

endmodule

// File: rtl/mtp_flash_chk.sv
module mtp_flash_chk #(
  parameter int unsigned VARIANT = 0
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ce_n,
  input logic       oe_n,
  input logic       we_n,
  input logic       oe_hv,
  input logic       a9_hv,
  input logic       addr0,
  input logic [7:0] dout,
  input logic       dout_en,
  input logic       busy,
  input logic       done
);

  localparam logic [7:0] DEV = mtp_pkg::dev_code(VARIANT);

  // R2
  read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n && !oe_hv && we_n) |-> dout_en);

  // R3
  hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || oe_n || oe_hv || !we_n) |-> !dout_en);

  // R7
  ident_maker_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n && !oe_hv && we_n && a9_hv && !addr0) |-> (dout == 8'hBF));

  // R7
  ident_dev_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n && !oe_hv && we_n && a9_hv && addr0) |-> (dout == DEV));

  // R8
  no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((we_n || ce_n) && !busy) |=> !busy);

  // R9
  hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  // R9
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

endmodule

bind mtp_flash mtp_flash_chk #(.VARIANT(VARIANT)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ce_n    (ce_n),
  .oe_n    (oe_n),
  .we_n    (we_n),
  .oe_hv   (oe_hv),
  .a9_hv   (a9_hv),
  .addr0   (addr[0]),
  .dout    (dout),
  .dout_en (dout_en),
  .busy    (busy),
  .done    (done)
);

// File: tb/mtp_flash_tb.sv
module mtp_flash_tb;

  localparam int CLK_P = 10;
  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;
  localparam int PC    = 5;
  localparam int EC    = 12;
  localparam int VAR   = 1;
  localparam logic [7:0] DEV = 8'hC5;

  logic clk, rst_n, ce_n, oe_n, we_n, oe_hv, a9_hv;
  logic [AW-1:0] addr;
  logic [7:0] din, dout;
  logic dout_en;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 0;
  logic [7:0] model [DEPTH];

  mtp_flash #(
    .ADDR_W (AW), .VARIANT (VAR), .PROG_CYC (PC), .ERASE_CYC (EC), .BUSY_ONES (1'b1)
  ) u_dut (
    .clk (clk), .rst_n (rst_n), .ce_n (ce_n), .oe_n (oe_n), .we_n (we_n),
    .oe_hv (oe_hv), .a9_hv (a9_hv), .addr (addr), .din (din),
    .dout (dout), .dout_en (dout_en)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic go_idle();
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; oe_hv = 1'b0; a9_hv = 1'b0;
    addr = '0; din = 8'h00;
  endtask

  // Set read levels at the next falling clock edge, sample 1 time unit later.
  task automatic read_expect(input logic [AW-1:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; oe_hv = 1'b0; a9_hv = 1'b0; addr = a;
    #1;
    check(dout_en === 1'b1, req, "read drive", {7'd0, dout_en}, 8'h01);
    check(dout === exp, req, "read data", dout, exp);
  endtask

  // One write-enable low pulse with program/erase levels; returns at the
  // falling clock edge after the edge that saw write enable low.
  task automatic pulse(input logic [AW-1:0] a, input logic [7:0] d, input logic a9);
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b1; oe_hv = 1'b1; a9_hv = a9; addr = a; din = d; we_n = 1'b0;
    @(negedge clk);
    we_n = 1'b1;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    for (int i = 0; i < DEPTH; i += 7) read_expect(AW'(i), 8'hFF, "R1");
    read_expect(AW'(DEPTH-1), 8'hFF, "R1");
  endtask

  task automatic t_hiz();
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b0; we_n = 1'b1; oe_hv = 1'b0; a9_hv = 1'b0; #1;
    check(dout_en === 1'b0, "R3", "ce high", {7'd0, dout_en}, 8'h00);
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b1; #1;
    check(dout_en === 1'b0, "R3", "oe high", {7'd0, dout_en}, 8'h00);
    @(negedge clk);
    oe_n = 1'b1; oe_hv = 1'b1; #1;
    check(dout_en === 1'b0, "R3", "oe high voltage", {7'd0, dout_en}, 8'h00);
    @(negedge clk);
    oe_hv = 1'b0; oe_n = 1'b0; we_n = 1'b0; #1;
    check(dout_en === 1'b0, "R3", "we low", {7'd0, dout_en}, 8'h00);
    @(negedge clk);
    we_n = 1'b1;
  endtask

  task automatic t_program();
    pulse(6'd5, 8'hA5, 1'b0); settle(PC + 1); model[5] = 8'hA5;
    read_expect(6'd5, 8'hA5, "R4");
    pulse(6'd9, 8'h3C, 1'b0); settle(PC + 1); model[9] = 8'h3C;
    read_expect(6'd9, 8'h3C, "R4");
    read_expect(6'd10, 8'hFF, "R2");
  endtask

  task automatic t_and();
    pulse(6'd5, 8'h0F, 1'b0); settle(PC + 1); model[5] = model[5] & 8'h0F;
    read_expect(6'd5, 8'h05, "R5");
    pulse(6'd5, 8'hFF, 1'b0); settle(PC + 1);
    read_expect(6'd5, model[5], "R5");
  endtask

  // Busy window: FF while counting (R10), new value on the first cycle after (R4).
  task automatic t_busy_window();
    pulse(6'd9, 8'h30, 1'b0);
    ce_n = 1'b0; oe_n = 1'b0; oe_hv = 1'b0; a9_hv = 1'b0; addr = 6'd9;
    #1;
    check(dout === 8'hFF, "R10", "busy read cycle 1", dout, 8'hFF);
    for (int j = 2; j <= PC; j++) begin
      @(negedge clk); #1;
      check(dout === 8'hFF, "R10", "busy read", dout, 8'hFF);
    end
    @(negedge clk); #1;
    model[9] = model[9] & 8'h30;
    check(dout === model[9], "R4", "value after busy", dout, model[9]);
  endtask

  task automatic t_ignore_busy();
    pulse(6'd20, 8'h00, 1'b0);
    pulse(6'd21, 8'h00, 1'b0);
    settle(PC + 2);
    model[20] = 8'h00;
    read_expect(6'd20, 8'h00, "R9");
    read_expect(6'd21, 8'hFF, "R9");
  endtask

  task automatic t_ident();
    logic [AW-1:0] al [4] = '{6'd0, 6'd1, 6'd42, 6'd43};
    for (int k = 0; k < 4; k++) begin
      logic [7:0] exp;
      exp = al[k][0] ? DEV : 8'hBF;
      @(negedge clk);
      ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; oe_hv = 1'b0; a9_hv = 1'b1; addr = al[k];
      #1;
      check(dout_en === 1'b1, "R7", "ident drive", {7'd0, dout_en}, 8'h01);
      check(dout === exp, "R7", "ident code", dout, exp);
    end
  endtask

  task automatic t_inhibit();
    // Program/erase levels held with write enable high.
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      ce_n = 1'b0; oe_n = 1'b1; oe_hv = 1'b1; we_n = 1'b1;
      a9_hv = k[0]; addr = AW'(k * 5); din = 8'h00;
    end
    // Write-enable pulses with chip enable high.
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      ce_n = 1'b1; oe_hv = 1'b1; a9_hv = k[0]; addr = 6'd9; din = 8'h00; we_n = 1'b0;
      @(negedge clk);
      we_n = 1'b1;
    end
    settle(EC + 2);
    read_expect(6'd9, model[9], "R8");
    read_expect(6'd5, model[5], "R8");
    read_expect(6'd0, 8'hFF, "R8");
    read_expect(6'd10, 8'hFF, "R8");
  endtask

  task automatic t_erase();
    pulse(6'd5, 8'h00, 1'b1);
    settle(EC + 1);
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    read_expect(6'd5, 8'hFF, "R6");
    read_expect(6'd9, 8'hFF, "R6");
    read_expect(6'd20, 8'hFF, "R6");
    for (int i = 1; i < DEPTH; i += 9) read_expect(AW'(i), 8'hFF, "R6");
    // Array still programmable after an erase.
    pulse(6'd33, 8'h5A, 1'b0); settle(PC + 1);
    read_expect(6'd33, 8'h5A, "R2");
  endtask

  initial begin
    go_idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_hiz();
    t_program();
    t_and();
    t_busy_window();
    t_ignore_busy();
    t_ident();
    t_inhibit();
    t_erase();
    go_idle();
    settle(2);
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 50000);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule